// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block drives a single conversion, or a short list of conversions, on an external serial analog-to-digital converter. The link has three outputs from the block: an active-low chip select, a serial data line toward the converter and a serial clock. A fourth line carries data from the converter back to the block. A one-cycle start pulse comes with a channel/configuration byte. The block then frames the transfer itself. It sends a formatted control byte, clocks an acquisition gap, reads back a 12-bit sample and releases the converter. It then reports the sample right-aligned in a 16-bit word.

In list mode a count and up to eight configuration bytes are taken at start. The channels are converted in list order, and each sample is streamed out as two byte writes (low byte, then high byte) into a buffer owned by the surrounding logic. The serial clock high and low times are set by parameters, in system clocks.

Top module: `adc_seq`

## Requirements
- R1: The byte sent for a conversion is (configuration byte AND 0x7C) OR 0x81. It goes out most significant bit first, one bit per serial clock pulse, and is valid on the data line at each rising serial clock edge.
- R2: Chip select falls before the first serial clock rise and rises only after the last of exactly 25 pulses. The serial clock idles low and never goes high while chip select is high.
- R3: Pulses 9 to 13 form the acquisition gap. During the gap the outgoing data line is held low and nothing is captured from the input line.
- R4: Pulses 14 to 17 capture sample bits 11 to 8, and pulses 18 to 25 capture bits 7 to 0. Each bit is read from the input line at the end of its pulse's high phase. The result is reported as {4'b0000, sample[11:0]}.
- R5: In single mode (list_mode_i low), done_o is a one-cycle pulse at the end of the conversion, and result_o holds the sample from that cycle on.
- R6: In list mode, list entry k is list_cfg_i[8k+7:8k]. Entries 0 to count-1 are converted in that order. Sample k is written as byte address 2k = low byte, then byte address 2k+1 = high byte, on two consecutive bw_en_o cycles. done_o pulses after the last write, and result_o holds the last sample.
- R7: A list count above 8 is treated as 8. A count of 0 produces a done_o pulse with no chip select activity and leaves result_o unchanged.
- R8: Every serial clock high phase lasts HI_CYC system clocks, and every low phase inside a frame lasts LO_CYC system clocks. The outgoing data line changes only while the serial clock is low.
- R9: busy_o rises the cycle after an accepted start and falls in the cycle done_o pulses. A start pulse while busy_o is high starts nothing.
- R10: After reset, chip select is high, the serial clock and data line are low, busy_o and done_o are low, and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start request |
| list_mode_i | input | 1 | 1 = convert the list, 0 = single conversion of cfg_i |
| cfg_i | input | 8 | Configuration byte for single mode |
| list_count_i | input | CNT_W | Number of list entries (clamped to MAX_CH) |
| list_cfg_i | input | 8*MAX_CH | Packed list configuration bytes, entry k in bits [8k+7:8k] |
| adc_sdi_i | input | 1 | Serial data from the converter |
| adc_cs_n_o | output | 1 | Active-low chip select |
| adc_sdo_o | output | 1 | Serial data to the converter |
| adc_sclk_o | output | 1 | Serial clock |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Last sample, right-aligned |
| bw_en_o | output | 1 | Buffer byte write strobe |
| bw_addr_o | output | ADDR_W | Buffer byte address |
| bw_data_o | output | 8 | Buffer byte data |

## Verification
The bench uses configuration bytes with every bit set, with no bit set and with alternating bits. A design that masked or forced the wrong bits would then send a wrong control byte. Samples of all ones, all zeros and a single set bit at either end of the sample show a nibble split misplaced by one pulse or a reversed bit order. The pulse count per frame shows an acquisition gap of four or six clocks. Lists of three entries, of twelve entries (clamped to eight) and of zero entries are run. An off-by-one in the list end, a swapped byte order or a missing clamp shows up as an extra, missing or misaddressed buffer write. A start pulse issued halfway through a conversion shows up as an extra frame if the block fails to ignore it.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and the control-byte formatter for the
// serial ADC sequencer. Assumes an 8-bit control word and a 12-bit sample.
package adc_seq_pkg;

    localparam int CTRL_BITS  = 8;
    localparam int ACQ_PULSES = 5;
    localparam int HI_NIB     = 4;
    localparam int LO_BYTE    = 8;
    localparam int SAMPLE_W   = HI_NIB + LO_BYTE;
    localparam int N_PULSE    = CTRL_BITS + ACQ_PULSES + SAMPLE_W;
    localparam int CAP_FIRST  = CTRL_BITS + ACQ_PULSES;
    localparam int IDX_W      = $clog2(N_PULSE);

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CONV,
        SEQ_WLO,
        SEQ_WHI
    } seq_state_t;

    // Keep channel/gain/polarity bits, force start bit and external clock bit.
    function automatic logic [7:0] fmt_ctrl(input logic [7:0] raw);
        return (raw & 8'h7C) | 8'h81;
    endfunction

endpackage

// File: rtl/adc_seq_clkdiv.sv
`timescale 1ns/1ps
// Phase timer for the serial clock. While run_i is high it counts system
// clocks in the current phase and raises tick_o on the last cycle of it.
// Assumes HI_CYC and LO_CYC are at least 1.
module adc_seq_clkdiv #(
    parameter int HI_CYC = 2,
    parameter int LO_CYC = 3,
    localparam int CW = $clog2(((HI_CYC > LO_CYC) ? HI_CYC : LO_CYC) + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic phase_hi_i,
    output logic tick_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // Pick the length of the phase that is running.
    always_comb begin
        limit  = phase_hi_i ? CW'(HI_CYC - 1) : CW'(LO_CYC - 1);
        tick_o = run_i && (cnt_q == limit);
    end

    // Count cycles of the current phase, restarting at each phase end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_seq_frame.sv
`timescale 1ns/1ps
// One converter frame: chip select low, 8 control bits, 5 acquisition
// pulses, 12 capture pulses, chip select high. fin_o pulses for one cycle
// with the sample on data_o. Assumes go_i is only raised while idle.
module adc_seq_frame
    import adc_seq_pkg::*;
#(
    parameter int HI_CYC = 2,
    parameter int LO_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_i,
    input  logic [7:0]          cfg_i,
    input  logic                sdi_i,
    output logic                cs_n_o,
    output logic                sdo_o,
    output logic                sclk_o,
    output logic                fin_o,
    output logic [SAMPLE_W-1:0] data_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_PULSE - 1);
    localparam logic [IDX_W-1:0] IDX_CAP  = IDX_W'(CAP_FIRST);

    logic                active_q;
    logic [IDX_W-1:0]    idx_q;
    logic [7:0]          ctl_sh_q;
    logic                sclk_q;
    logic                cs_n_q;
    logic                sdo_q;
    logic                fin_q;
    logic [SAMPLE_W-1:0] sh_q;
    logic                tick;

    adc_seq_clkdiv #(
        .HI_CYC (HI_CYC),
        .LO_CYC (LO_CYC)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (active_q),
        .phase_hi_i (sclk_q),
        .tick_o     (tick)
    );

    // Step through the pulses of a frame; move data only on the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            ctl_sh_q <= '0;
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            sdo_q    <= 1'b0;
            fin_q    <= 1'b0;
            sh_q     <= '0;
        end else begin
            fin_q <= 1'b0;
            if (!active_q) begin
                if (go_i) begin
                    active_q <= 1'b1;
                    idx_q    <= '0;
                    ctl_sh_q <= fmt_ctrl(cfg_i);
                    sdo_q    <= fmt_ctrl(cfg_i) >> 7;
                    cs_n_q   <= 1'b0;
                    sclk_q   <= 1'b0;
                end
            end else if (tick) begin
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else begin
                    sclk_q   <= 1'b0;
                    ctl_sh_q <= {ctl_sh_q[6:0], 1'b0};
                    if (idx_q >= IDX_CAP) begin
                        sh_q <= {sh_q[SAMPLE_W-2:0], sdi_i};
                    end
                    if (idx_q == IDX_LAST) begin
                        active_q <= 1'b0;
                        cs_n_q   <= 1'b1;
                        fin_q    <= 1'b1;
                        sdo_q    <= 1'b0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        sdo_q <= ctl_sh_q[6];
                    end
                end
            end
        end
    end

    assign cs_n_o = cs_n_q;
    assign sdo_o  = sdo_q;
    assign sclk_o = sclk_q;
    assign fin_o  = fin_q;
    assign data_o = sh_q;

endmodule

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
// Serial ADC conversion sequencer. Runs one frame per start in single mode,
// or walks a list of up to MAX_CH configuration bytes and writes each sample
// as two bytes (low, high) into an external buffer. Assumes MAX_CH >= 2.
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int  HI_CYC = 2,
    parameter int  LO_CYC = 3,
    parameter int  MAX_CH = 8,
    localparam int CH_W   = $clog2(MAX_CH),
    localparam int CNT_W  = $clog2(MAX_CH + 1),
    localparam int ADDR_W = CH_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  list_mode_i,
    input  logic [7:0]            cfg_i,
    input  logic [CNT_W-1:0]      list_count_i,
    input  logic [8*MAX_CH-1:0]   list_cfg_i,
    input  logic                  adc_sdi_i,
    output logic                  adc_cs_n_o,
    output logic                  adc_sdo_o,
    output logic                  adc_sclk_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [15:0]           result_o,
    output logic                  bw_en_o,
    output logic [ADDR_W-1:0]     bw_addr_o,
    output logic [7:0]            bw_data_o
);

    logic [7:0]          cfg_arr [MAX_CH];
    logic [7:0]          lst_q   [MAX_CH];
    seq_state_t          st_q;
    logic                list_q;
    logic [CH_W-1:0]     ch_q;
    logic [CH_W-1:0]     last_q;
    logic [7:0]          cur_cfg_q;
    logic                go_q;
    logic                busy_q;
    logic                done_q;
    logic [15:0]         res_q;
    logic                bw_en_q;
    logic [ADDR_W-1:0]   bw_addr_q;
    logic [7:0]          bw_data_q;
    logic [CNT_W-1:0]    cnt_eff;
    logic                fin;
    logic [SAMPLE_W-1:0] sample;

    // Unpack the list bus into one byte per entry.
    for (genvar g = 0; g < MAX_CH; g++) begin : g_unpack
        assign cfg_arr[g] = list_cfg_i[8*g +: 8];
    end

    // Clamp the requested list length to the list capacity.
    always_comb begin
        cnt_eff = (list_count_i > CNT_W'(MAX_CH)) ? CNT_W'(MAX_CH) : list_count_i;
    end

    adc_seq_frame #(
        .HI_CYC (HI_CYC),
        .LO_CYC (LO_CYC)
    ) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go_q),
        .cfg_i  (cur_cfg_q),
        .sdi_i  (adc_sdi_i),
        .cs_n_o (adc_cs_n_o),
        .sdo_o  (adc_sdo_o),
        .sclk_o (adc_sclk_o),
        .fin_o  (fin),
        .data_o (sample)
    );

    // Sequence control: accept start, launch frames, write bytes, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= SEQ_IDLE;
            list_q    <= 1'b0;
            ch_q      <= '0;
            last_q    <= '0;
            cur_cfg_q <= '0;
            go_q      <= 1'b0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            res_q     <= '0;
            bw_en_q   <= 1'b0;
            bw_addr_q <= '0;
            bw_data_q <= '0;
            for (int i = 0; i < MAX_CH; i++) lst_q[i] <= '0;
        end else begin
            go_q    <= 1'b0;
            done_q  <= 1'b0;
            bw_en_q <= 1'b0;
            unique case (st_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        list_q <= list_mode_i;
                        ch_q   <= '0;
                        for (int i = 0; i < MAX_CH; i++) lst_q[i] <= cfg_arr[i];
                        if (list_mode_i && cnt_eff == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            busy_q    <= 1'b1;
                            go_q      <= 1'b1;
                            st_q      <= SEQ_CONV;
                            last_q    <= CH_W'(cnt_eff - 1'b1);
                            cur_cfg_q <= list_mode_i ? cfg_arr[0] : cfg_i;
                        end
                    end
                end
                SEQ_CONV: begin
                    if (fin) begin
                        res_q <= {{(16-SAMPLE_W){1'b0}}, sample};
                        if (list_q) begin
                            st_q <= SEQ_WLO;
                        end else begin
                            done_q <= 1'b1;
                            busy_q <= 1'b0;
                            st_q   <= SEQ_IDLE;
                        end
                    end
                end
                SEQ_WLO: begin
                    bw_en_q   <= 1'b1;
                    bw_addr_q <= {ch_q, 1'b0};
                    bw_data_q <= res_q[7:0];
                    st_q      <= SEQ_WHI;
                end
                SEQ_WHI: begin
                    bw_en_q   <= 1'b1;
                    bw_addr_q <= {ch_q, 1'b1};
                    bw_data_q <= res_q[15:8];
                    if (ch_q == last_q) begin
                        done_q <= 1'b1;
                        busy_q <= 1'b0;
                        st_q   <= SEQ_IDLE;
                    end else begin
                        ch_q      <= ch_q + 1'b1;
                        cur_cfg_q <= lst_q[ch_q + 1'b1];
                        go_q      <= 1'b1;
                        st_q      <= SEQ_CONV;
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign result_o  = res_q;
    assign bw_en_o   = bw_en_q;
    assign bw_addr_o = bw_addr_q;
    assign bw_data_o = bw_data_q;

endmodule

// File: rtl/adc_seq_checker.sv
`timescale 1ns/1ps
// Protocol checker for adc_seq: serial clock framing, phase widths,
// data-line timing and the busy/done handshake. Bound to every adc_seq.
module adc_seq_checker #(
    parameter int HI_CYC = 2,
    parameter int LO_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic busy,
    input logic done
);

    logic [15:0] hi_run_q;
    logic [15:0] lo_run_q;

    // Length of the current high and in-frame low runs of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= sclk ? hi_run_q + 1'b1 : '0;
            lo_run_q <= (!sclk && !cs_n) ? lo_run_q + 1'b1 : '0;
        end
    end

    a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    a_r8_sdo_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> !sclk);

    a_r8_hi_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> hi_run_q == 16'(HI_CYC));

    a_r8_lo_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> lo_run_q == 16'(LO_CYC));

    a_r5_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_busy_ends_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r9_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

endmodule

bind adc_seq adc_seq_checker #(
    .HI_CYC (HI_CYC),
    .LO_CYC (LO_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (adc_cs_n_o),
    .sclk  (adc_sclk_o),
    .sdo   (adc_sdo_o),
    .busy  (busy_o),
    .done  (done_o)
);

// File: tb/adc_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for adc_seq: driver tasks queue expected control bytes,
// samples, results and buffer writes; a converter model and a monitor
// compare them as the design produces them.
module adc_seq_bench;

    localparam int HI  = 2;
    localparam int LO  = 3;
    localparam int MCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        list_mode_i = 1'b0;
    logic [7:0]  cfg_i = '0;
    logic [3:0]  list_count_i = '0;
    logic [63:0] list_cfg_i = '0;
    logic        adc_sdi_i = 1'b0;
    logic        adc_cs_n_o, adc_sdo_o, adc_sclk_o, busy_o, done_o;
    logic [15:0] result_o;
    logic        bw_en_o;
    logic [3:0]  bw_addr_o;
    logic [7:0]  bw_data_o;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    int frames_exp = 0;
    int hi_bad = 0;
    int hi_seen = 0;

    logic [11:0] adc_q [$];
    logic [7:0]  ctrl_q [$];
    logic [15:0] res_q [$];
    logic [11:0] wr_q [$];
    logic [15:0] last_res = '0;

    always #10 clk = ~clk;

    adc_seq #(.HI_CYC(HI), .LO_CYC(LO), .MAX_CH(MCH)) u_adc_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .list_mode_i(list_mode_i),
        .cfg_i(cfg_i), .list_count_i(list_count_i), .list_cfg_i(list_cfg_i),
        .adc_sdi_i(adc_sdi_i), .adc_cs_n_o(adc_cs_n_o), .adc_sdo_o(adc_sdo_o),
        .adc_sclk_o(adc_sclk_o), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .bw_en_o(bw_en_o), .bw_addr_o(bw_addr_o),
        .bw_data_o(bw_data_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl_of(input logic [7:0] c);
        return {1'b1, c[6:2], 2'b01};
    endfunction

    // Converter model: checks the control byte, the gap and the pulse count.
    initial begin
        forever begin
            logic [11:0] v;
            logic [7:0]  ec, rx;
            int k;
            bit gap_bad;
            @(negedge adc_cs_n_o);
            frames_seen++;
            v = '0; ec = '0; rx = '0; k = 0; gap_bad = 0;
            if (adc_q.size() > 0) begin
                v  = adc_q.pop_front();
                ec = ctrl_q.pop_front();
            end
            while (!adc_cs_n_o) begin
                @(posedge adc_sclk_o or posedge adc_cs_n_o);
                if (adc_cs_n_o) break;
                k++;
                if (k <= 8) rx = {rx[6:0], adc_sdo_o};
                else if (k <= 13) begin
                    if (adc_sdo_o) gap_bad = 1;
                end
                if (k >= 14 && k <= 25) begin
                    #1 adc_sdi_i = v[25-k];
                end
            end
            chk(rx == ec, "R1 control byte", rx, ec);
            chk(k == 25, "R2 pulses per frame", k, 25);
            chk(!gap_bad, "R3 data low in gap", gap_bad, 0);
        end
    end

    // Measure each high phase of the serial clock.
    initial begin
        int run = 0;
        forever begin
            @(negedge clk);
            if (adc_sclk_o) run++;
            else if (run != 0) begin
                hi_seen++;
                if (run != HI) hi_bad++;
                run = 0;
            end
        end
    end

    // Monitor: compare results and buffer writes against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                logic [15:0] e;
                e = (res_q.size() > 0) ? res_q.pop_front() : 16'hDEAD;
                chk(result_o == e, "R4 R5 result", result_o, e);
            end
            if (bw_en_o) begin
                logic [11:0] w;
                w = (wr_q.size() > 0) ? wr_q.pop_front() : 12'hFFF;
                chk({bw_addr_o, bw_data_o} == w, "R6 buffer write",
                    {bw_addr_o, bw_data_o}, w);
            end
        end
    end

    task automatic fire(input bit lm, input logic [7:0] c, input logic [3:0] n,
                        input logic [63:0] lc, input bit expect_busy);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        start_i = 1'b1; list_mode_i = lm; cfg_i = c;
        list_count_i = n; list_cfg_i = lc;
        @(negedge clk);
        start_i = 1'b0;
        if (expect_busy) chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_single(input logic [7:0] c, input logic [11:0] v);
        adc_q.push_back(v);
        ctrl_q.push_back(ctl_of(c));
        last_res = {4'h0, v};
        res_q.push_back(last_res);
        frames_exp++;
        fire(1'b0, c, 4'd0, 64'd0, 1'b1);
        wait_idle();
    endtask

    task automatic run_list(input logic [3:0] n, input logic [63:0] lc,
                            input logic [95:0] vals);
        int eff;
        eff = (n > MCH) ? MCH : n;
        for (int k = 0; k < eff; k++) begin
            logic [11:0] v;
            v = vals[12*k +: 12];
            adc_q.push_back(v);
            ctrl_q.push_back(ctl_of(lc[8*k +: 8]));
            wr_q.push_back({4'(2*k), v[7:0]});
            wr_q.push_back({4'(2*k+1), 4'h0, v[11:8]});
            last_res = {4'h0, v};
            frames_exp++;
        end
        res_q.push_back(last_res);
        fire(1'b1, 8'h00, n, lc, eff != 0);
        wait_idle();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus.
    initial begin
        logic [63:0] lc;
        logic [95:0] vs;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(adc_cs_n_o == 1'b1, "R10 cs high in reset", adc_cs_n_o, 1);
        chk(adc_sclk_o == 1'b0 && adc_sdo_o == 1'b0, "R10 sclk/sdo low",
            {adc_sclk_o, adc_sdo_o}, 0);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R10 busy/done low", {busy_o, done_o}, 0);
        chk(result_o == 16'h0, "R10 result zero", result_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R4 R5 single conversions with varied bytes and samples
        run_single(8'hFF, 12'hABC);
        run_single(8'h00, 12'h000);
        run_single(8'h55, 12'hFFF);
        run_single(8'hAA, 12'h800);
        run_single(8'h7C, 12'h001);

        // R9 start while busy is ignored
        adc_q.push_back(12'h5A5);
        ctrl_q.push_back(ctl_of(8'h3A));
        last_res = 16'h05A5;
        res_q.push_back(last_res);
        frames_exp++;
        fire(1'b0, 8'h3A, 4'd0, 64'd0, 1'b1);
        repeat (40) @(negedge clk);
        start_i = 1'b1; cfg_i = 8'h00;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9 still busy after ignored start", busy_o, 1);
        wait_idle();
        chk(frames_seen == frames_exp, "R9 no extra frame", frames_seen, frames_exp);

        // R6 list of three
        lc = 64'h0; vs = 96'h0;
        lc[7:0] = 8'h04; lc[15:8] = 8'h08; lc[23:16] = 8'h7C;
        vs[11:0] = 12'h123; vs[23:12] = 12'h800; vs[35:24] = 12'h001;
        run_list(4'd3, lc, vs);

        // R7 list count above capacity is clamped
        for (int k = 0; k < 8; k++) begin
            lc[8*k +: 8]  = 8'(8'h11 * k + 8'h06);
            vs[12*k +: 12] = 12'(12'h1F3 * (k + 1));
        end
        run_list(4'd12, lc, vs);

        // R7 empty list: done, no frame, result unchanged
        run_list(4'd0, lc, vs);
        chk(frames_seen == frames_exp, "R7 no frame for empty list", frames_seen, frames_exp);

        // R8 high phase width
        chk(hi_bad == 0 && hi_seen > 0, "R8 sclk high width", hi_bad, 0);
        chk(adc_q.size() == 0 && res_q.size() == 0 && wr_q.size() == 0,
            "R6 scoreboard drained", adc_q.size() + res_q.size() + wr_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule